// File: doc/BRIEF.md
# Scripted Bus Master Sequencer

This block is a Wishbone master that runs a short stored program. Each program word holds an opcode, an address and a data value. The opcode selects one of four actions:

- a single read, which checks the returned data against the expected value held in the word;
- a single write;
- one idle clock with the bus cycle kept open;
- one idle clock with the bus cycle released.

Words run strictly in memory order. Nothing is inserted between them beyond what the program asks for.

A verification environment or a bring-up harness loads the program through a valid/ready write port. It sets a program length and pulses `start`. The master then drives the bus until the program ends, and raises `done`. Any read whose data differs from the expected value sets a sticky `error` flag and bumps a saturating mismatch counter. Reads that match leave both unchanged.

The load port applies back-pressure. `prog_ready` is high only while no program is executing. A word is written into the program store on a clock edge where `prog_valid` and `prog_ready` are both high. A word presented while `prog_ready` is low is not taken, and the source must hold it until `prog_ready` rises.

Top module: `wb_script_master`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `done` and `error` are low, `mism_cnt` is zero and `prog_ready` is high.
- R2: A program word is 40 bits wide, laid out as follows:
  - bits [39:36] hold the opcode;
  - bits [35:24] hold the address;
  - bits [23:0] hold the data.
  
  The opcodes are 0 for read, 1 for write, 2 for hold-open idle and 3 for release idle. The first word runs from index 0, and the clock after `start` is the first clock of that word.
- R3: A write drives `wb_cyc_o`, `wb_stb_o` and `wb_we_o` high, with the word's address and data on `wb_adr_o` and `wb_dat_o`. These stay stable until `wb_ack_i` is sampled high, and the next word begins on the following clock.
- R4: A read drives `wb_we_o` low. When `wb_ack_i` is sampled high, a `wb_dat_i` that differs from the word's data field sets `error` and increments `mism_cnt`, which saturates at its maximum. A match changes neither.
- R5: A hold-open word produces exactly one clock with `wb_cyc_o` high and `wb_stb_o` low.
- R6: A release word produces exactly one clock with `wb_cyc_o` low while the program is still executing.
- R7: Consecutive read and write words keep `wb_cyc_o` high with no gap between them.
- R8: The address and data fields of hold-open and release words have no effect: no bus transfer happens and no slave location changes.
- R9: When the next word's index reaches `prog_len`, execution stops. `done` then goes high and `wb_cyc_o` goes low.
- R10: A word with an opcode above 3 stops execution in the same way, and no later word runs.
- R11: `start` while idle or done restarts execution at index 0 and clears `error` and `mism_cnt`. `start` while a program is executing is ignored.
- R12: `prog_ready` is low while a program is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_valid | input | 1 | Program word offered |
| prog_ready | output | 1 | Program store can accept a word |
| prog_addr | input | $clog2(DEPTH) | Program store index |
| prog_word | input | OP_W+ADDR_W+DATA_W | Program word |
| prog_len | input | $clog2(DEPTH)+1 | Number of words to execute |
| start | input | 1 | Begin execution pulse |
| done | output | 1 | Execution finished |
| error | output | 1 | Sticky read mismatch flag |
| mism_cnt | output | CNT_W | Saturating read mismatch count |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W | Bus address |
| wb_dat_o | output | DATA_W | Write data |
| wb_dat_i | input | DATA_W | Read data |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The bench runs five kinds of program against a slave model with 0 to 3 clocks of acknowledge latency:

- **Write-then-read with zero latency.** This shows that back-to-back transfers keep the cycle open and that data reaches the slave.
- **Mixed program with both idle opcodes and junk fields.** This separates a one-clock hold from a one-clock release and shows that the idle fields are ignored.
- **Program with deliberately wrong expected values.** This separates the sticky flag from the count.
- **Early-stop programs.** One stops on the length limit and one on an undefined opcode. Each shows that no later word reaches the bus, and the length-limit run also shows that a restart clears the error state.
- **Restart attempt mid-run.** A `start` pulse during execution must not repeat any transfer.

// File: rtl/wbsm_pkg.sv
package wbsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_HOLD,
    ST_DROP,
    ST_DONE
  } wbsm_state_e;

  localparam int OPC_READ  = 0;
  localparam int OPC_WRITE = 1;
  localparam int OPC_HOLD  = 2;
  localparam int OPC_DROP  = 3;
endpackage

// File: rtl/wbsm_imem.sv
module wbsm_imem #(
  parameter int WORD_W = 40,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
  end

  assign rd_word = store[rd_idx];
endmodule

// File: rtl/wbsm_seq.sv
module wbsm_seq
  import wbsm_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PC_W   = IDX_W + 1,
  localparam int WORD_W = OP_W + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PC_W-1:0]   prog_len,
  output logic [IDX_W-1:0]  fetch_idx,
  input  logic [WORD_W-1:0] fetch_word,
  input  logic              ack,
  output logic              cyc,
  output logic              stb,
  output logic              we,
  output logic [ADDR_W-1:0] adr,
  output logic [DATA_W-1:0] dat,
  output logic              busy,
  output logic              done,
  output logic              launch,
  output logic              rd_done
);
  wbsm_state_e state_q, state_d;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   next_pc;
  logic              advance;
  logic              issue;
  logic              past_end;
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_adr;
  logic [DATA_W-1:0] f_dat;

  assign f_op  = fetch_word[WORD_W-1 -: OP_W];
  assign f_adr = fetch_word[DATA_W +: ADDR_W];
  assign f_dat = fetch_word[DATA_W-1:0];

  assign launch  = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign advance = (state_q == ST_XFER && ack) || state_q == ST_HOLD || state_q == ST_DROP;
  assign issue   = launch || advance;
  assign next_pc = launch ? '0 : pc_q + 1'b1;
  assign fetch_idx = next_pc[IDX_W-1:0];
  assign past_end  = (next_pc >= prog_len) || (next_pc >= PC_W'(DEPTH));

  always_comb begin
    state_d = state_q;
    if (issue) begin
      if (past_end) state_d = ST_DONE;
      else begin
        case (int'(f_op))
          OPC_READ, OPC_WRITE: state_d = ST_XFER;
          OPC_HOLD:            state_d = ST_HOLD;
          OPC_DROP:            state_d = ST_DROP;
          default:             state_d = ST_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      we      <= 1'b0;
      adr     <= '0;
      dat     <= '0;
    end else begin
      state_q <= state_d;
      if (issue) pc_q <= next_pc;
      if (issue && state_d == ST_XFER) begin
        we  <= (int'(f_op) == OPC_WRITE);
        adr <= f_adr;
        dat <= f_dat;
      end
    end
  end

  assign cyc     = (state_q == ST_XFER) || (state_q == ST_HOLD);
  assign stb     = (state_q == ST_XFER);
  assign busy    = (state_q == ST_XFER) || (state_q == ST_HOLD) || (state_q == ST_DROP);
  assign done    = (state_q == ST_DONE);
  assign rd_done = (state_q == ST_XFER) && ack && !we;
endmodule

// File: rtl/wbsm_cmp.sv
module wbsm_cmp #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] expected,
  output logic              error,
  output logic [CNT_W-1:0]  count
);
  logic miss;
  assign miss = rd_done && (rd_data != expected);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      error <= 1'b0;
      count <= '0;
    end else if (clr) begin
      error <= 1'b0;
      count <= '0;
    end else if (miss) begin
      error <= 1'b1;
      if (count != {CNT_W{1'b1}}) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/wb_script_master.sv
module wb_script_master #(
  parameter int OP_W   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_valid,
  output logic                          prog_ready,
  input  logic [$clog2(DEPTH)-1:0]      prog_addr,
  input  logic [OP_W+ADDR_W+DATA_W-1:0] prog_word,
  input  logic [$clog2(DEPTH):0]        prog_len,
  input  logic                          start,
  output logic                          done,
  output logic                          error,
  output logic [CNT_W-1:0]              mism_cnt,
  output logic                          wb_cyc_o,
  output logic                          wb_stb_o,
  output logic                          wb_we_o,
  output logic [ADDR_W-1:0]             wb_adr_o,
  output logic [DATA_W-1:0]             wb_dat_o,
  input  logic [DATA_W-1:0]             wb_dat_i,
  input  logic                          wb_ack_i
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WORD_W = OP_W + ADDR_W + DATA_W;

  logic [IDX_W-1:0]  fetch_idx;
  logic [WORD_W-1:0] fetch_word;
  logic              busy;
  logic              launch;
  logic              rd_done;

  assign prog_ready = !busy;

  wbsm_imem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_imem (
    .clk     (clk),
    .wr_en   (prog_valid && prog_ready),
    .wr_idx  (prog_addr),
    .wr_word (prog_word),
    .rd_idx  (fetch_idx),
    .rd_word (fetch_word)
  );

  wbsm_seq #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .prog_len   (prog_len),
    .fetch_idx  (fetch_idx),
    .fetch_word (fetch_word),
    .ack        (wb_ack_i),
    .cyc        (wb_cyc_o),
    .stb        (wb_stb_o),
    .we         (wb_we_o),
    .adr        (wb_adr_o),
    .dat        (wb_dat_o),
    .busy       (busy),
    .done       (done),
    .launch     (launch),
    .rd_done    (rd_done)
  );

  wbsm_cmp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .rd_done  (rd_done),
    .rd_data  (wb_dat_i),
    .expected (wb_dat_o),
    .error    (error),
    .count    (mism_cnt)
  );
endmodule

// File: rtl/wbsm_checker.sv
module wbsm_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              prog_ready,
  input logic              done,
  input logic              error,
  input logic [CNT_W-1:0]  mism_cnt,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic              wb_we_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              wb_ack_i
);
  // R1: the first clock out of reset shows an idle bus
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wb_cyc_o && !done && !error));

  // R3: request fields held until acknowledged
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_dat_o) && $stable(wb_we_o)));

  // R3: strobe only inside an open cycle
  a_r3_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb_o |-> wb_cyc_o);

  // R4: mismatch flag is sticky until a restart
  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

  // R4: mismatch count never falls without a restart
  a_r4_cnt_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (mism_cnt >= $past(mism_cnt)));

  // R9: stopped master releases the bus
  a_r9_done_no_cyc: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wb_cyc_o);

  // R12: no loads accepted while the bus cycle is open
  a_r12_busy_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> !prog_ready);
endmodule

bind wb_script_master wbsm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .prog_ready (prog_ready),
  .done       (done),
  .error      (error),
  .mism_cnt   (mism_cnt),
  .wb_cyc_o   (wb_cyc_o),
  .wb_stb_o   (wb_stb_o),
  .wb_we_o    (wb_we_o),
  .wb_adr_o   (wb_adr_o),
  .wb_dat_o   (wb_dat_o),
  .wb_ack_i   (wb_ack_i)
);

// File: tb/tb_wb_script_master.sv
`timescale 1ns/1ps
module tb_wb_script_master;
  localparam int OP_W = 4, ADDR_W = 12, DATA_W = 24, DEPTH = 16, CNT_W = 8;
  localparam int WORD_W = OP_W + ADDR_W + DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_valid = 1'b0;
  logic prog_ready;
  logic [3:0] prog_addr = '0;
  logic [WORD_W-1:0] prog_word = '0;
  logic [4:0] prog_len = '0;
  logic start = 1'b0;
  logic done, error;
  logic [CNT_W-1:0] mism_cnt;
  logic wb_cyc_o, wb_stb_o, wb_we_o;
  logic [ADDR_W-1:0] wb_adr_o;
  logic [DATA_W-1:0] wb_dat_o;
  logic [DATA_W-1:0] wb_dat_i = '0;
  logic wb_ack_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0;
  int n_hold = 0, n_drop = 0, n_xfer = 0, n_unstable = 0;
  logic [DATA_W-1:0] smem [16];
  logic prev_wait = 1'b0;
  logic [ADDR_W-1:0] prev_adr = '0;

  always #4 clk = ~clk;

  wb_script_master #(.OP_W(OP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_word(prog_word), .prog_len(prog_len), .start(start),
    .done(done), .error(error), .mism_cnt(mism_cnt), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_we_o(wb_we_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
  );

  // slave model with programmable acknowledge latency
  initial begin
    for (int i = 0; i < 16; i++) smem[i] = '0;
    forever begin
      @(posedge clk);
      if (!rst_n) wb_ack_i <= 1'b0;
      else if (wb_cyc_o && wb_stb_o && !wb_ack_i) begin
        if (wcnt == lat) begin
          wb_ack_i <= 1'b1;
          wcnt <= 0;
          if (wb_we_o) smem[wb_adr_o[3:0]] <= wb_dat_o;
          else wb_dat_i <= smem[wb_adr_o[3:0]];
        end else wcnt <= wcnt + 1;
      end else wb_ack_i <= 1'b0;
    end
  end

  // bus monitor, sampled at the falling edge
  initial forever begin
    @(negedge clk);
    if (wb_cyc_o && !wb_stb_o) n_hold++;
    if (!wb_cyc_o && !prog_ready) n_drop++;
    if (wb_stb_o && wb_ack_i) n_xfer++;
    if (prev_wait && wb_stb_o && wb_adr_o != prev_adr) n_unstable++;
    prev_wait = wb_stb_o && !wb_ack_i;
    prev_adr  = wb_adr_o;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  function automatic logic [WORD_W-1:0] mk(input int op, input int adr, input int dat);
    return {op[3:0], adr[11:0], dat[23:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [WORD_W-1:0] w);
    @(negedge clk);
    prog_valid = 1'b1; prog_addr = idx[3:0]; prog_word = w;
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic run(input int len);
    int t;
    prog_len = len[4:0];
    @(negedge clk);
    n_hold = 0; n_drop = 0; n_xfer = 0; n_unstable = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk("R9 done reached", done, 1);
    chk("R9 cyc low when done", wb_cyc_o, 0);
  endtask

  task automatic t_reset();
    chk("R1 cyc", wb_cyc_o, 0);
    chk("R1 stb", wb_stb_o, 0);
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 count", mism_cnt, 0);
    chk("R1 ready", prog_ready, 1);
  endtask

  task automatic t_write_read();
    lat = 0;
    load(0, mk(1, 1, 'hA1)); load(1, mk(1, 2, 'hB2)); load(2, mk(1, 3, 'hC3));
    load(3, mk(0, 1, 'hA1)); load(4, mk(0, 2, 'hB2)); load(5, mk(0, 3, 'hC3));
    run(6);
    chk("R3 slave word 1", smem[1], 'hA1);
    chk("R3 slave word 3", smem[3], 'hC3);
    chk("R2 transfer count", n_xfer, 6);
    chk("R7 no gap in cyc", n_drop, 0);
    chk("R3 stable request", n_unstable, 0);
    chk("R4 no mismatch", error, 0);
  endtask

  task automatic t_idles();
    lat = 2;
    load(0, mk(1, 5, 'h55)); load(1, mk(2, 'hFFF, 'hFFFFFF)); load(2, mk(0, 5, 'h55));
    load(3, mk(3, 'hFFF, 'h123456)); load(4, mk(0, 5, 'h55)); load(5, mk(1, 6, 'h66));
    run(6);
    chk("R5 one hold clock", n_hold, 1);
    chk("R6 one release clock", n_drop, 1);
    chk("R8 idle words no transfer", n_xfer, 4);
    chk("R8 junk address untouched", smem[15], 0);
    chk("R3 write after idles", smem[6], 'h66);
    chk("R3 stable under latency", n_unstable, 0);
  endtask

  task automatic t_mismatch();
    lat = 1;
    load(0, mk(0, 1, 'h000000)); load(1, mk(0, 2, 'hB2)); load(2, mk(0, 3, 'h999));
    run(3);
    chk("R4 error set", error, 1);
    chk("R4 count two", mism_cnt, 2);
    chk("R4 all reads ran", n_xfer, 3);
  endtask

  task automatic t_len_stop();
    lat = 0;
    load(0, mk(1, 7, 'h71)); load(1, mk(1, 8, 'h81)); load(2, mk(1, 9, 'h91));
    run(2);
    chk("R9 two transfers", n_xfer, 2);
    chk("R9 word past length not run", smem[9], 0);
    chk("R11 restart cleared error", error, 0);
    chk("R11 restart cleared count", mism_cnt, 0);
  endtask

  task automatic t_bad_opcode();
    load(0, mk(1, 10, 'hAA)); load(1, mk(5, 11, 'hBB)); load(2, mk(1, 11, 'hBB));
    run(3);
    chk("R10 one transfer", n_xfer, 1);
    chk("R10 later word not run", smem[11], 0);
  endtask

  task automatic t_restart_ignored();
    int t;
    lat = 3;
    load(0, mk(1, 12, 'hC1)); load(1, mk(1, 13, 'hD1)); load(2, mk(1, 14, 'hE1));
    prog_len = 5'd3;
    @(negedge clk);
    n_xfer = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 ready low while running", prog_ready, 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk("R11 mid-run start ignored", n_xfer, 3);
    chk("R12 ready back when done", prog_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_read();
    t_idles();
    t_mismatch();
    t_len_stop();
    t_bad_opcode();
    t_restart_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule